// File: doc/BRIEF.md
# Pin Edge Event Detector

This block watches a bank of general-purpose input pins and records edge events on them. Each pin has two enable bits: one arms detection of a low-to-high transition and the other arms detection of a high-to-low transition. Software sets these bits through separate register arrays. The pins are asynchronous to the clock, so each one passes through a two-stage synchronizer. An edge is then found by comparing the synchronized value with its value one cycle earlier.

When an armed edge occurs, a sticky status bit for that pin is set. The bit stays set until software writes a one to it; writing a zero to it changes nothing. A single interrupt request is the OR of every status bit, taken through one register. Host software services the interrupt by reading the status words, handling each flagged pin, and writing the same bits back to clear them.

Access is through a plain 32-bit register port. Reads return data combinationally from the byte address. Writes take effect on the rising clock edge on which the write strobe is high.

Top module: `pin_edge_events`

## Requirements
- R1: After reset, every enable bit and every status bit is 0 and `irq_o` is 0.
- R2: Address map. Status word k is at byte offset 0x40+4k, rising-enable word k is at 0x4C+4k, and falling-enable word k is at 0x58+4k. Pin n occupies bit n mod 32 of word n/32. Every other address reads as 0.
- R3: The enable words can be written and read back. Bits for pin numbers at or above NPINS always read 0.
- R4: When a pin goes from 0 to 1 and its rising enable is 1, its status bit reads 1 from the third rising clock edge after the pin changes.
- R5: When a pin goes from 1 to 0 and its falling enable is 1, its status bit reads 1 from the third rising clock edge after the pin changes.
- R6: A transition whose direction is not enabled on that pin sets no status bit, and it sets no bit of any other pin.
- R7: Writing 1 to a status bit clears it. Writing 0 to a status bit leaves it unchanged.
- R8: If an enabled edge and a write of 1 reach the same status bit on the same clock edge, the bit stays 1.
- R9: Clearing an enable bit does not clear a status bit that is already set.
- R10: `irq_o` equals the OR of all status bits as they were one clock cycle earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins_i | input | NPINS | Raw pin levels, asynchronous to `clk` |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | AW | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| irq_o | output | 1 | Registered OR of all status bits |

## Verification
The bench builds the block with NPINS=40. This gives two words per register array, and the upper word holds only eight real pins. Every pin is swept under all four enable combinations in both edge directions, so any decode slip or bit crossing shows up in the status words. The partial upper word makes the unimplemented-bit masking visible. The bench also places a clear and a fresh event on the same clock edge to check which one takes priority.

// File: rtl/pin_edge_events.sv
module pin_edge_events #(
  parameter int NPINS = 54,
  parameter int AW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pins_i,
  input  logic             bus_wr,
  input  logic [AW-1:0]    bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  output logic             irq_o
);
  localparam int NW = (NPINS + 31) / 32;
  localparam int PW = NW * 32;
  localparam int STAT_BASE = 'h40;
  localparam int RISE_BASE = 'h4C;
  localparam int FALL_BASE = 'h58;
  localparam logic [PW-1:0] VMASK = {PW{1'b1}} >> (PW - NPINS);

  logic [PW-1:0] pin_w, sync_a, sync_b, last_q;
  logic [PW-1:0] rise_en, fall_en, stat_q;
  logic [PW-1:0] ev, clr;

  assign pin_w = PW'(pins_i);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync_a <= '0;
      sync_b <= '0;
      last_q <= '0;
    end else begin
      sync_a <= pin_w & VMASK;
      sync_b <= sync_a;
      last_q <= sync_b;
    end

  assign ev = (sync_b & ~last_q & rise_en) | (~sync_b & last_q & fall_en);

  always_comb begin
    clr = '0;
    for (int k = 0; k < NW; k++)
      if (bus_wr && bus_addr == AW'(STAT_BASE + 4 * k))
        clr[32*k +: 32] = bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rise_en <= '0;
      fall_en <= '0;
      stat_q  <= '0;
      irq_o   <= 1'b0;
    end else begin
      for (int k = 0; k < NW; k++) begin
        if (bus_wr && bus_addr == AW'(RISE_BASE + 4 * k))
          rise_en[32*k +: 32] <= bus_wdata & VMASK[32*k +: 32];
        if (bus_wr && bus_addr == AW'(FALL_BASE + 4 * k))
          fall_en[32*k +: 32] <= bus_wdata & VMASK[32*k +: 32];
      end
      stat_q <= ((stat_q & ~clr) | ev) & VMASK;
      irq_o  <= |stat_q;
    end

  always_comb begin
    bus_rdata = '0;
    for (int k = 0; k < NW; k++) begin
      if (bus_addr == AW'(STAT_BASE + 4 * k)) bus_rdata = stat_q[32*k +: 32];
      if (bus_addr == AW'(RISE_BASE + 4 * k)) bus_rdata = rise_en[32*k +: 32];
      if (bus_addr == AW'(FALL_BASE + 4 * k)) bus_rdata = fall_en[32*k +: 32];
    end
  end

  // R4/R5/R6: a status bit only rises after an enabled edge on its pin
  a_r6_set_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_q & ~$past(stat_q) & ~$past(ev)) == '0));

  // R8: an event always lands, even against a clear
  a_r8_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_q & $past(ev)) == $past(ev)));

  // R7/R9: a status bit only drops after a write of one to it
  a_r7_clear_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    ((~stat_q & $past(stat_q) & ~$past(clr)) == '0));

  // R10: interrupt follows status with one cycle of lag
  a_r10_irq_lag: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o == $past(stat_q != '0)));
endmodule

// File: tb/pin_edge_events_tb.sv
module pin_edge_events_tb_top;
  localparam int CLK_P = 10;
  localparam int NP = 40;

  logic clk = 0, rst_n = 0, bus_wr = 0;
  logic [NP-1:0] pins = '0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic irq;
  int total = 0, bad = 0;
  logic [31:0] rv;

  pin_edge_events #(.NPINS(NP), .AW(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .pins_i(pins), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq));

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(posedge clk); @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk_stat(input string tag, input logic [63:0] exp);
    logic [31:0] v;
    rd(8'h40, v); chk({tag, " w0"}, v, exp[31:0]);
    rd(8'h44, v); chk({tag, " w1"}, v, exp[63:32]);
  endtask

  task automatic clear_all();
    wr(8'h40, '1); wr(8'h44, '1); cyc(1);
  endtask

  initial begin
    #(CLK_P * 200000);
    bad++; total++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 256; a += 4) begin
      rd(a[7:0], rv); chk("R1 reset read", rv, 0);
    end
    chk("R1 irq at reset", {31'b0, irq}, 0);
    rst_n = 1;
    cyc(2);

    // R3 enable read back, unimplemented bits masked; R2 map
    wr(8'h4C, 32'hA5A5_5A5A); rd(8'h4C, rv); chk("R3 rise w0", rv, 32'hA5A5_5A5A);
    wr(8'h50, '1); rd(8'h50, rv); chk("R3 rise w1 mask", rv, 32'h0000_00FF);
    wr(8'h58, 32'h1234_5678); rd(8'h58, rv); chk("R3 fall w0", rv, 32'h1234_5678);
    wr(8'h5C, 32'hFFFF_FF3C); rd(8'h5C, rv); chk("R3 fall w1 mask", rv, 32'h0000_003C);
    rd(8'h54, rv); chk("R2 gap reads 0", rv, 0);
    rd(8'h48, rv); chk("R2 gap reads 0", rv, 0);
    wr(8'h4C, 0); wr(8'h50, 0); wr(8'h58, 0); wr(8'h5C, 0);

    // R4 R5 R6 R7 R10: exhaustive sweep over pins and enable modes
    for (int p = 0; p < NP; p++) begin
      for (int m = 0; m < 4; m++) begin
        logic [63:0] bit_p;
        bit_p = 64'd1 << p;
        wr(8'h4C, m[0] ? bit_p[31:0] : 32'h0);
        wr(8'h50, m[0] ? bit_p[63:32] : 32'h0);
        wr(8'h58, m[1] ? bit_p[31:0] : 32'h0);
        wr(8'h5C, m[1] ? bit_p[63:32] : 32'h0);
        pins[p] = 1'b1;
        cyc(4);
        chk_stat(m[0] ? "R4 rise sets" : "R6 rise ignored", m[0] ? bit_p : 64'h0);
        chk("R10 irq after rise", {31'b0, irq}, {31'b0, m[0]});
        if (m[0]) begin
          wr(8'h40, 0); wr(8'h44, 0); cyc(1);
          chk_stat("R7 zero write keeps", bit_p);
        end
        clear_all();
        chk_stat("R7 one write clears", 64'h0);
        chk("R10 irq after clear", {31'b0, irq}, 0);
        pins[p] = 1'b0;
        cyc(4);
        chk_stat(m[1] ? "R5 fall sets" : "R6 fall ignored", m[1] ? bit_p : 64'h0);
        chk("R10 irq after fall", {31'b0, irq}, {31'b0, m[1]});
        clear_all();
      end
    end

    // Multiple pins at once across both words
    wr(8'h4C, '1); wr(8'h50, '1); wr(8'h58, 0); wr(8'h5C, 0);
    pins[3] = 1; pins[35] = 1;
    cyc(4);
    chk_stat("R4 two pins", (64'd1 << 3) | (64'd1 << 35));
    // R7 partial clear of one word
    wr(8'h44, 32'h8); cyc(1);
    chk_stat("R7 partial clear", 64'd1 << 3);

    // R9 disabling keeps status
    wr(8'h4C, 0); wr(8'h50, 0); cyc(1);
    chk_stat("R9 disable keeps", 64'd1 << 3);
    chk("R9 irq held", {31'b0, irq}, 1);

    // R8 event and clear on same edge (pin 3 falling, bit already set)
    wr(8'h58, 32'h8);
    pins[3] = 0;
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    wr(8'h40, 32'h8);
    chk_stat("R8 event wins", 64'd1 << 3);
    wr(8'h40, 32'h8); cyc(2);
    chk_stat("R8 later clear", 64'h0);
    chk("R10 irq final", {31'b0, irq}, 0);
    pins[35] = 0;
    cyc(4);
    chk_stat("R6 no enable pin35", 64'h0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule